// File: doc/BRIEF.md
# Per-Lane Write Strobe Delay Search Engine

This engine runs on the controller side of a memory interface. It finds, for each byte lane, the setting of an external programmable delay line that places the outgoing data strobe's rising edge on the memory clock edge as seen at the device. During leveling, the device samples its clock on each strobe edge and returns the sampled level on that lane's data bits. The engine moves up through the delay codes one step at a time. For each step it drives the code, waits for the line to settle, requests one strobe pulse, waits out the feedback latency and samples the returned level. A lane stops at the first code whose level reads 1 after a 0 has been seen at a lower code.

The lanes share one step sequencer, but each lane keeps its own code, its own history and its own result. A lane that has finished holds its code while the other lanes keep searching. Software sets the timing through configuration inputs, enables the lanes it wants, pulses `start` and waits for `done`. It then reads the codes and the per-lane lock and fail flags.

Top module: `wl_dly_search`

## Requirements
- R1: After synchronous active-low reset, every lane code is 0. All lock and fail flags are 0, `done`, `busy` and `strobe_req` are 0, and the sequencer is idle. A reset taken in the middle of a search has the same effect.
- R2: Each step holds the lane codes for at least `cfg_settle` cycles and then raises `strobe_req` for exactly one cycle. Sampling starts no earlier than `cfg_latency` cycles after that pulse. Each step issues exactly one pulse, so a search with no repeated steps issues as many pulses as the most steps any enabled lane needs, and at least one pulse.
- R3: While a lane has not resolved, its code rises by exactly 1 after each step that ends in agreeing samples. The code does not change at any other time during a search.
- R4: A lane locks at the first code whose voted level is 1 after a 0 was seen at some lower code in the same search. A 1 read before any 0 is stepped past.
- R5: Each lane is searched independently. Lane k takes its feedback from `fb[k*FB_BITS +: FB_BITS]` and drives `dly_code[k*CODE_W +: CODE_W]`. Lane 0 is the lower byte and lane 1 is the upper byte.
- R6: Within a lane, the feedback bits are combined by majority vote. The level is 1 only when more than half of the bits are 1, so a tie counts as 0.
- R7: Each step takes `cfg_samples` consecutive samples, with 0 treated as 1. If the samples do not all agree, the step is repeated and the code does not advance.
- R8: A lane that evaluates the maximum code (127 by default) without locking raises its fail flag and keeps that code.
- R9: `done` rises only when every lane enabled at `start` has locked or failed, and `busy` is low while `done` is high. A lane disabled at `start` keeps code 0 with both flags low.
- R10: After `done`, codes and flags hold until the next accepted `start`. An accepted `start` clears codes and flags. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search (accepted when idle) |
| lane_en | input | LANES | Lanes to search, captured at start |
| cfg_settle | input | 8 | Settle cycles after a code change |
| cfg_latency | input | 8 | Cycles from strobe pulse to first sample |
| cfg_samples | input | 4 | Samples per step (0 means 1) |
| fb | input | LANES*FB_BITS | Sampled clock level returned per lane |
| dly_code | output | LANES*CODE_W | Delay code per lane |
| strobe_req | output | 1 | One-cycle strobe pulse request |
| busy | output | 1 | Search in progress |
| done | output | 1 | All enabled lanes resolved |
| lane_lock | output | LANES | Lane found its 0-to-1 transition |
| lane_fail | output | LANES | Lane reached the top code without locking |

## Verification
The hardest case to reach from the ports is a step whose samples disagree, because a clean delay-to-level model always returns a steady level. The bench adds a glitch source that inverts one lane's feedback on every clock while four samples are taken per step. It then checks that this lane stays at code 0 while the other lane locks on its own. Once the glitch is removed, the stalled lane finishes at the expected code. Tie votes, minority-flipped bits and a leading band of 1s are produced with directed feedback patterns, and the strobe pulse count is compared against the number of steps each run should take.

// File: rtl/wl_pkg.sv
// Shared types for the strobe delay search engine.
package wl_pkg;
    // Phases of one search step, plus idle and the end-of-step check.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_PULSE,
        SQ_LAT,
        SQ_SAMP,
        SQ_EVAL,
        SQ_CHECK
    } sq_state_t;
endpackage

// File: rtl/wl_vote.sv
// Majority vote over the feedback bits of one lane.
// The output is 1 only if strictly more than half of the bits are 1, so a tie gives 0.
// Assumes BITS >= 1. Purely combinational.
module wl_vote #(
    parameter int BITS = 4
) (
    input  logic [BITS-1:0] bits,
    output logic            level
);
    localparam int CW = $clog2(BITS + 1);

    logic [CW-1:0] ones;

    // Count the 1 bits and compare twice that count with the width.
    always_comb begin
        ones = '0;
        for (int i = 0; i < BITS; i++) begin
            ones = ones + CW'(bits[i]);
        end
        level = ({1'b0, ones, 1'b0} > (CW + 2)'(BITS));
    end
endmodule

// File: rtl/wl_seq.sv
// Step sequencer shared by all lanes.
// One step is: settle, one-cycle strobe pulse, latency wait, N samples, evaluate,
// then a check of whether every enabled lane has resolved.
// Assumes CNT_W > SMP_W. start is accepted only in idle.
module wl_seq
    import wl_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SMP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             all_res,
    input  logic [CNT_W-1:0] cfg_settle,
    input  logic [CNT_W-1:0] cfg_latency,
    input  logic [SMP_W-1:0] cfg_samples,
    output logic             clr,
    output logic             strobe,
    output logic             samp_en,
    output logic             samp_first,
    output logic             eval,
    output logic             busy,
    output logic             done
);
    sq_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [SMP_W-1:0] nsamp;
    logic             last_samp;

    // Decode the sample count, treating 0 as 1.
    always_comb begin
        nsamp     = (cfg_samples == '0) ? SMP_W'(1) : cfg_samples;
        last_samp = (cnt == CNT_W'(nsamp) - CNT_W'(1));
    end

    // Strobes that follow directly from the phase.
    always_comb begin
        clr        = start && (state == SQ_IDLE);
        strobe     = (state == SQ_PULSE);
        samp_en    = (state == SQ_SAMP);
        samp_first = (state == SQ_SAMP) && (cnt == '0);
        eval       = (state == SQ_EVAL);
        busy       = (state != SQ_IDLE);
    end

    // Phase register and phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    cnt <= '0;
                    if (start) state <= SQ_SETTLE;
                end
                SQ_SETTLE: begin
                    if (cnt >= cfg_settle) begin
                        state <= SQ_PULSE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_PULSE: begin
                    state <= SQ_LAT;
                    cnt   <= '0;
                end
                SQ_LAT: begin
                    if (cnt >= cfg_latency) begin
                        state <= SQ_SAMP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_SAMP: begin
                    if (last_samp) begin
                        state <= SQ_EVAL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_EVAL: begin
                    state <= SQ_CHECK;
                end
                SQ_CHECK: begin
                    cnt   <= '0;
                    state <= all_res ? SQ_IDLE : SQ_SETTLE;
                end
                default: begin
                    state <= SQ_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Completion flag: set on the final check, cleared by reset or a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (clr) begin
            done <= 1'b0;
        end else if (state == SQ_CHECK && all_res) begin
            done <= 1'b1;
        end
    end

    // R2: the strobe request is a single-cycle pulse.
    a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R2: sampling begins only after the pulse and the latency wait.
    a_r2_samp_after_lat: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !samp_en);

    // R9: done and busy never overlap.
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/wl_lane.sv
// One byte lane of the search.
// Votes its feedback bits, checks that the samples of a step agree, and on each
// evaluation either locks (a 1 after a seen 0), steps the code up by one, or fails
// at the top code. Assumes the sequencer never pulses eval while sampling.
module wl_lane #(
    parameter int CODE_W  = 7,
    parameter int FB_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              act,
    input  logic [FB_BITS-1:0] fb_bits,
    input  logic              samp_en,
    input  logic              samp_first,
    input  logic              eval,
    output logic [CODE_W-1:0] code,
    output logic              locked,
    output logic              failed
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic lvl;
    logic first_lvl;
    logic agree;
    logic seen0;
    logic open_lane;

    wl_vote #(.BITS(FB_BITS)) u_vote (
        .bits  (fb_bits),
        .level (lvl)
    );

    // A lane takes part in an evaluation only while it is enabled and unresolved.
    always_comb open_lane = act && !locked && !failed;

    // Sample agreement tracking within one step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            first_lvl <= 1'b0;
            agree     <= 1'b0;
        end else if (samp_first) begin
            first_lvl <= lvl;
            agree     <= 1'b1;
        end else if (samp_en && (lvl != first_lvl)) begin
            agree <= 1'b0;
        end
    end

    // Search state: delay code, zero-seen history and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code   <= '0;
            seen0  <= 1'b0;
            locked <= 1'b0;
            failed <= 1'b0;
        end else if (eval && open_lane && agree) begin
            if (first_lvl && seen0) begin
                locked <= 1'b1;
            end else begin
                if (!first_lvl) seen0 <= 1'b1;
                if (code == CODE_MAX) failed <= 1'b1;
                else                  code   <= code + CODE_W'(1);
            end
        end
    end

    // R3: outside an evaluation or a clear, the code does not move.
    a_r3_code_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval && !clr) |=> (code == $past(code)));

    // R3: an evaluation moves the code by at most one, upward.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !clr) |=> (code == $past(code) || code == $past(code) + CODE_W'(1)));

    // R4: a lock needs a 0 earlier in the same search, and excludes failure.
    a_r4_lock_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (seen0 && !failed));

    // R8: a failed lane sits at the top code.
    a_r8_fail_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> (code == CODE_MAX));
endmodule

// File: rtl/wl_dly_search.sv
// Top of the strobe delay search engine.
// Captures the lane enables at start, runs one shared step sequencer and
// one search lane per byte lane, and reports when all enabled lanes resolved.
// Assumes the feedback is steady from the end of settling to the last sample.
module wl_dly_search #(
    parameter int LANES   = 2,
    parameter int FB_BITS = 4,
    parameter int CODE_W  = 7,
    parameter int CNT_W   = 8,
    parameter int SMP_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LANES-1:0]          lane_en,
    input  logic [CNT_W-1:0]          cfg_settle,
    input  logic [CNT_W-1:0]          cfg_latency,
    input  logic [SMP_W-1:0]          cfg_samples,
    input  logic [LANES*FB_BITS-1:0]  fb,
    output logic [LANES*CODE_W-1:0]   dly_code,
    output logic                      strobe_req,
    output logic                      busy,
    output logic                      done,
    output logic [LANES-1:0]          lane_lock,
    output logic [LANES-1:0]          lane_fail
);
    logic [LANES-1:0] en_q;
    logic             clr;
    logic             samp_en;
    logic             samp_first;
    logic             eval;
    logic             all_res;

    // Lane enables are frozen for the whole search.
    always_ff @(posedge clk) begin
        if (!rst_n)   en_q <= '0;
        else if (clr) en_q <= lane_en;
    end

    // Every enabled lane has either locked or failed.
    always_comb all_res = &(~en_q | lane_lock | lane_fail);

    wl_seq #(.CNT_W(CNT_W), .SMP_W(SMP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .all_res     (all_res),
        .cfg_settle  (cfg_settle),
        .cfg_latency (cfg_latency),
        .cfg_samples (cfg_samples),
        .clr         (clr),
        .strobe      (strobe_req),
        .samp_en     (samp_en),
        .samp_first  (samp_first),
        .eval        (eval),
        .busy        (busy),
        .done        (done)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        wl_lane #(.CODE_W(CODE_W), .FB_BITS(FB_BITS)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr),
            .act        (en_q[k]),
            .fb_bits    (fb[k*FB_BITS +: FB_BITS]),
            .samp_en    (samp_en),
            .samp_first (samp_first),
            .eval       (eval),
            .code       (dly_code[k*CODE_W +: CODE_W]),
            .locked     (lane_lock[k]),
            .failed     (lane_fail[k])
        );

        // R9: a lane left out of the search never moves or resolves.
        a_r9_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[k] && !clr) |=> (dly_code[k*CODE_W +: CODE_W] == '0
                                    && !lane_lock[k] && !lane_fail[k]));
    end

    // R9: done only when every enabled lane is resolved.
    a_r9_done_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> all_res);

    // R10: results hold after completion until a new start.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(dly_code) && $stable(lane_lock) && $stable(lane_fail)));
endmodule

// File: tb/sim_wl_dly_search.sv
// Self-checking bench: a behavioural device model returns, per lane, a level
// set by the current code (a leading band of 1s, then 0s, then 1s from a threshold).
module sim_wl_dly_search;
    localparam int LANES = 2;
    localparam int FBB   = 4;
    localparam int CW    = 7;
    localparam int CMAX  = 127;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [LANES-1:0]       lane_en = '0;
    logic [7:0]             cfg_settle = '0;
    logic [7:0]             cfg_latency = '0;
    logic [3:0]             cfg_samples = 4'd1;
    logic [LANES*FBB-1:0]   fb;
    logic [LANES*CW-1:0]    dly_code;
    logic                   strobe_req, busy, done;
    logic [LANES-1:0]       lane_lock, lane_fail;

    int  hi_band [LANES];
    int  thr     [LANES];
    int  mode    [LANES];
    bit  glitch_on [LANES];
    bit  glitch_tog = 1'b0;
    int  n_chk = 0;
    int  n_bad = 0;
    int  pulses = 0;

    always #2.5 clk = ~clk;

    wl_dly_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_en(lane_en),
        .cfg_settle(cfg_settle), .cfg_latency(cfg_latency), .cfg_samples(cfg_samples),
        .fb(fb), .dly_code(dly_code), .strobe_req(strobe_req), .busy(busy),
        .done(done), .lane_lock(lane_lock), .lane_fail(lane_fail)
    );

    // Clock level the device would see at a given code.
    function automatic bit dev_level(int c, int h, int t);
        return (c < h) ? 1'b1 : (c >= t);
    endfunction

    // Level after the vote: mode 2 delivers 1 as a 2-of-4 tie, which counts as 0.
    function automatic bit voted_level(int c, int h, int t, int m);
        return (m == 2) ? 1'b0 : dev_level(c, h, t);
    endfunction

    // Expected final code and lock state from the search rule.
    function automatic int exp_code(int h, int t, int m, output bit lk);
        bit s0 = 1'b0;
        lk = 1'b0;
        for (int c = 0; c <= CMAX; c++) begin
            if (!voted_level(c, h, t, m)) s0 = 1'b1;
            else if (s0) begin
                lk = 1'b1;
                return c;
            end
        end
        return CMAX;
    endfunction

    // Feedback bits: mode 0 all equal, mode 1 one bit flipped, mode 2 tie for a 1.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            logic [FBB-1:0] b;
            bit lv;
            lv = dev_level(int'(dly_code[k*CW +: CW]), hi_band[k], thr[k]);
            case (mode[k])
                1:       b = lv ? 4'b1011 : 4'b0100;
                2:       b = lv ? 4'b0101 : 4'b0000;
                default: b = lv ? 4'b1111 : 4'b0000;
            endcase
            if (glitch_on[k] && glitch_tog) b = ~b;
            fb[k*FBB +: FBB] = b;
        end
    end

    always @(negedge clk) glitch_tog <= ~glitch_tog;
    always @(posedge clk) if (strobe_req) pulses <= pulses + 1;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int code_of(int k);
        return int'(dly_code[k*CW +: CW]);
    endfunction

    task automatic go(logic [LANES-1:0] en, int st, int lt, int sm);
        @(negedge clk);
        lane_en = en; cfg_settle = 8'(st); cfg_latency = 8'(lt); cfg_samples = 4'(sm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulses = 0;
    endtask

    task automatic wait_done(int limit);
        int n = 0;
        while (!done && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
        end
    endtask

    // Run one search and compare every lane with the expected result.
    task automatic run_and_check(logic [LANES-1:0] en, int st, int lt, int sm, string tag);
        int steps = 1;
        go(en, st, lt, sm);
        wait_done(8000);
        check({tag, " R9 done"}, done, 1);
        check({tag, " R9 busy low"}, busy, 0);
        for (int k = 0; k < LANES; k++) begin
            bit lk;
            int ec;
            ec = exp_code(hi_band[k], thr[k], mode[k], lk);
            if (en[k]) begin
                if (ec + 1 > steps) steps = ec + 1;
                check({tag, " R4 code"}, code_of(k), ec);
                check({tag, " R4 lock"}, lane_lock[k], lk);
                check({tag, " R8 fail"}, lane_fail[k], !lk);
            end else begin
                check({tag, " R9 disabled code"}, code_of(k), 0);
                check({tag, " R9 disabled flags"}, {lane_lock[k], lane_fail[k]}, 0);
            end
        end
        check({tag, " R2 pulses"}, pulses, steps);
    endtask

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        for (int k = 0; k < LANES; k++) begin
            hi_band[k] = 0; thr[k] = 5; mode[k] = 0; glitch_on[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 codes", int'(dly_code), 0);
        check("R1 flags", {lane_lock, lane_fail}, 0);
        check("R1 done/busy/strobe", {done, busy, strobe_req}, 0);

        // R4/R5: directed, lanes at different thresholds, lane 1 with leading 1s.
        hi_band[0] = 0;  thr[0] = 5;
        hi_band[1] = 9;  thr[1] = 90;
        run_and_check(2'b11, 1, 2, 2, "dir_indep");

        // R10: results hold while idle, then a start while busy is ignored.
        repeat (20) @(negedge clk);
        check("R10 hold lane0", code_of(0), 5);
        check("R10 hold lane1", code_of(1), 90);

        // R6: minority-flipped bits still vote correctly; tie reads as 0 and fails.
        mode[0] = 1; hi_band[0] = 3; thr[0] = 40;
        mode[1] = 2; hi_band[1] = 0; thr[1] = 20;
        run_and_check(2'b11, 0, 0, 1, "dir_vote");
        check("R6 tie lane fails", lane_fail[1], 1);
        check("R8 tie lane at max", code_of(1), CMAX);

        // R8: all-ones lane never sees a 0 and fails at the top code.
        mode[0] = 0; hi_band[0] = 200; thr[0] = 300;
        mode[1] = 0; hi_band[1] = 0;   thr[1] = 127;
        run_and_check(2'b11, 0, 1, 1, "dir_max");

        // R7/R5: glitching lane 0 cannot advance; lane 1 locks on its own.
        hi_band[0] = 2; thr[0] = 30; glitch_on[0] = 1'b1;
        hi_band[1] = 0; thr[1] = 10;
        go(2'b11, 0, 0, 4);
        repeat (400) @(negedge clk);
        check("R7 stalled code", code_of(0), 0);
        check("R5 other lane locks", {lane_lock[1], code_of(1)}, {1'b1, 32'd10});
        check("R10 start ignored busy", busy, 1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R10 start ignored code", code_of(1), 10);
        glitch_on[0] = 1'b0;
        wait_done(8000);
        check("R7 recovered code", code_of(0), 30);
        check("R7 recovered lock", lane_lock[0], 1);

        // R1: reset in mid-search.
        go(2'b11, 2, 2, 2);
        repeat (150) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset codes", int'(dly_code), 0);
        check("R1 mid reset state", {busy, done, lane_lock, lane_fail}, 0);

        // Random searches.
        for (int i = 0; i < 20; i++) begin
            for (int k = 0; k < LANES; k++) begin
                hi_band[k] = $urandom_range(0, 20);
                thr[k]     = hi_band[k] + 1 + $urandom_range(0, 120);
                mode[k]    = $urandom_range(0, 1);
            end
            run_and_check(2'($urandom_range(0, 3)), $urandom_range(0, 3),
                          $urandom_range(0, 3), $urandom_range(0, 4), "rand R3");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Global watchdog.
    initial begin
        #(190000 * 5);
        n_chk++; n_bad++;
        $display("FAIL R9 global watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule